// File: doc/BRIEF.md
# Keyed Flash Command Front End

This block is the register-side controller of an on-chip flash array. A host reaches it over a simple single-cycle register bus. It holds a timing mode register, a page data buffer, a keyed command register and a status register. There is also a read window that returns the stored word of any page. The array is modelled as one 32-bit word per page. The program and erase time is modelled by a busy counter whose length comes from the mode register.

A command word written with the right key byte is checked against the lock state and its index range. If it passes, the block starts one of these operations: page program, erase of the whole array, lock or unlock of a sector region, or set or clear of a general-purpose non-volatile bit. The ready flag stays low while the operation runs, and the operation takes effect when the busy period ends. Lock and unlock report completion through their own end-of-lock flag. Commands that fail a check are not executed and raise sticky error flags. Reading the status register clears those flags.

Register map, by byte address: 0x00 is the mode register and 0x04 is the command register (write-only, reads return 0). 0x08 is the status register and 0x0C is the page buffer. When address bit AW-1 is set, the access is a read window and page p is read at 0x80 + 4·p. Reads are combinational and take effect on the clock edge that samples req_i.

Top module: `flc_ctrl`

## Requirements
- R1: After reset the status register reads ready=1 at bit 0, with every other status bit 0 except bit 4, which follows sec_i. The mode register reads 0 and every page reads 0xFFFFFFFF.
- R2: The command word carries the key 0x5A in bits 31:24, the page or bit index in bits 17:8 and the opcode in bits 7:0. A word with any other key is not executed: ready stays 1 and programming-error bit 3 is set.
- R3: An unknown opcode is rejected with bit 3 set and nothing is executed. The valid opcodes are 0x01 page write, 0x02 lock, 0x04 unlock, 0x08 erase-all, 0x0B bit set and 0x0D bit clear. A page index of NUM_PAGES or more on write, lock or unlock is also rejected this way, and so is a bit index of NUM_GP or more on set or clear.
- R4: The mode register holds a cycle count FMCN in bits 23:16 and a wait-state select FWS at bit 8. Ready drops after the clock edge that accepts a command. It stays low for exactly (FMCN+1)<<FWS cycles.
- R5: A command written while ready is low is rejected with bit 3 set. It has no effect, and the running operation completes unchanged.
- R6: Page write (0x01) stores the page buffer word, captured when the command is accepted, into page p. The stored word reads back at 0x80+4·p after completion.
- R7: A page write aimed at a locked region is aborted. Lock-error bit 2 is set, ready stays 1 and the page keeps its old contents.
- R8: Lock (0x02) and unlock (0x04) on page p change the whole region p / PAGES_PER_REGION. Region n is shown at status bit 16+n.
- R9: Accepting a lock or unlock command clears end-of-lock bit 1, and the flag is set again when that command completes. Other commands leave bit 1 unchanged.
- R10: Erase-all (0x08) sets every page to 0xFFFFFFFF. If any region lock bit is set, it is refused with bit 2 and the array stays unchanged.
- R11: Bit set (0x0B) and bit clear (0x0D) with index b change general-purpose bit b, which is shown at status bit 8+b.
- R12: A status read returns bits 2 and 3 and then clears them. A new error raised on the same edge stays set.
- R13: Status bit 4 always follows the security input sec_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Byte address |
| wdata_i | input | 32 | Write data |
| sec_i | input | 1 | Security bit state, shown at status bit 4 |
| rdata_o | output | 32 | Combinational read data |

## Verification
The assertions check on every cycle that an accepted command puts the timer into busy, and that no command is accepted while busy. They check that decode errors reach the sticky error flags on the next edge, and that a status read clears the programming-error flag. They also check that region lock bits change, and that the end-of-lock flag rises, only right after a busy period ends. The bench scenarios show the rest: the exact busy length for each timing setting, the data stored in each page, whole-region locking from any page inside the region, refusal of writes and erase-all while locked, and the general-purpose bits.

// File: rtl/flc_pkg.sv
package flc_pkg;
  localparam logic [7:0] CMD_KEY = 8'h5A;
  localparam int FMCN_W = 8;

  typedef enum logic [7:0] {
    OP_WRITE  = 8'h01,
    OP_LOCK   = 8'h02,
    OP_UNLOCK = 8'h04,
    OP_ERASE  = 8'h08,
    OP_GP_SET = 8'h0B,
    OP_GP_CLR = 8'h0D
  } flc_op_e;

  localparam logic [7:0] OFF_MODE = 8'h00;
  localparam logic [7:0] OFF_CMD  = 8'h04;
  localparam logic [7:0] OFF_STAT = 8'h08;
  localparam logic [7:0] OFF_BUF  = 8'h0C;

  localparam int ST_RDY  = 0;
  localparam int ST_EOL  = 1;
  localparam int ST_LERR = 2;
  localparam int ST_PERR = 3;
  localparam int ST_SEC  = 4;
  localparam int ST_GP   = 8;
  localparam int ST_LOCK = 16;

  function automatic logic is_lock_op(flc_op_e op);
    return (op == OP_LOCK) || (op == OP_UNLOCK);
  endfunction
endpackage

// File: rtl/flc_cmd_decode.sv
module flc_cmd_decode
  import flc_pkg::*;
#(
  parameter int NUM_REGIONS      = 8,
  parameter int PAGES_PER_REGION = 4,
  parameter int NUM_GP           = 3,
  localparam int NUM_PAGES       = NUM_REGIONS * PAGES_PER_REGION,
  localparam int PG_W            = $clog2(NUM_PAGES)
) (
  input  logic                   cmd_wr_i,
  input  logic [31:0]            word_i,
  input  logic                   busy_i,
  input  logic [NUM_REGIONS-1:0] lock_i,
  output logic                   accept_o,
  output logic                   prog_err_o,
  output logic                   lock_err_o,
  output flc_op_e                op_o,
  output logic [PG_W-1:0]        pn_o
);
  localparam int RSH   = $clog2(PAGES_PER_REGION);
  localparam int RGN_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

  logic [9:0]       pn_full;
  logic [RGN_W-1:0] rgn;
  logic             key_ok, known, range_ok, locked_hit, bad;
  logic             unused_bits;

  assign pn_full     = word_i[17:8];
  assign rgn         = RGN_W'(pn_full >> RSH);
  assign key_ok      = (word_i[31:24] == CMD_KEY);
  assign unused_bits = ^word_i[23:18];

  always_comb begin
    known      = 1'b1;
    range_ok   = 1'b1;
    locked_hit = 1'b0;
    case (word_i[7:0])
      OP_WRITE: begin
        range_ok   = 32'(pn_full) < NUM_PAGES;
        locked_hit = range_ok && lock_i[rgn];
      end
      OP_LOCK, OP_UNLOCK:   range_ok = 32'(pn_full) < NUM_PAGES;
      OP_ERASE:             locked_hit = |lock_i;
      OP_GP_SET, OP_GP_CLR: range_ok = 32'(pn_full) < NUM_GP;
      default:              known = 1'b0;
    endcase
  end

  // busy rejection takes priority over all other checks
  assign bad        = !key_ok || !known || !range_ok || busy_i;
  assign prog_err_o = cmd_wr_i && bad;
  assign lock_err_o = cmd_wr_i && !bad && locked_hit;
  assign accept_o   = cmd_wr_i && !bad && !locked_hit;
  assign op_o       = flc_op_e'(word_i[7:0]);
  assign pn_o       = pn_full[PG_W-1:0];
endmodule

// File: rtl/flc_busy_timer.sv
module flc_busy_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= len_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/flc_nvm_store.sv
module flc_nvm_store
  import flc_pkg::*;
#(
  parameter int NUM_REGIONS      = 8,
  parameter int PAGES_PER_REGION = 4,
  parameter int NUM_GP           = 3,
  localparam int NUM_PAGES       = NUM_REGIONS * PAGES_PER_REGION,
  localparam int PG_W            = $clog2(NUM_PAGES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   done_i,
  input  flc_op_e                op_i,
  input  logic [PG_W-1:0]        pn_i,
  input  logic [31:0]            data_i,
  input  logic [PG_W-1:0]        rd_idx_i,
  output logic [31:0]            rd_data_o,
  output logic [NUM_REGIONS-1:0] lock_o,
  output logic [NUM_GP-1:0]      gp_o
);
  localparam int RSH   = $clog2(PAGES_PER_REGION);
  localparam int RGN_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
  localparam int GP_W  = (NUM_GP > 1) ? $clog2(NUM_GP) : 1;

  logic [31:0]            mem_q [NUM_PAGES];
  logic [NUM_REGIONS-1:0] lock_q;
  logic [NUM_GP-1:0]      gp_q;
  logic [RGN_W-1:0]       rgn;
  logic [GP_W-1:0]        gpi;

  assign rgn = RGN_W'(pn_i >> RSH);
  assign gpi = pn_i[GP_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < NUM_PAGES; p++) mem_q[p] <= '1;
      lock_q <= '0;
      gp_q   <= '0;
    end else if (done_i) begin
      case (op_i)
        OP_WRITE:  mem_q[pn_i] <= data_i;
        OP_ERASE:  for (int p = 0; p < NUM_PAGES; p++) mem_q[p] <= '1;
        OP_LOCK:   lock_q[rgn] <= 1'b1;
        OP_UNLOCK: lock_q[rgn] <= 1'b0;
        OP_GP_SET: gp_q[gpi]   <= 1'b1;
        OP_GP_CLR: gp_q[gpi]   <= 1'b0;
        default: ;
      endcase
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];
  assign lock_o    = lock_q;
  assign gp_o      = gp_q;
endmodule

// File: rtl/flc_ctrl.sv
module flc_ctrl
  import flc_pkg::*;
#(
  parameter int NUM_REGIONS      = 8,
  parameter int PAGES_PER_REGION = 4,
  parameter int NUM_GP           = 3,
  parameter int AW               = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  input  logic          sec_i,
  output logic [31:0]   rdata_o
);
  localparam int NUM_PAGES = NUM_REGIONS * PAGES_PER_REGION;
  localparam int PG_W      = $clog2(NUM_PAGES);
  localparam int CNT_W     = FMCN_W + 2;
  localparam int WIN_W     = AW - 2;

  logic wr_mode, wr_cmd, wr_buf, rd_stat, win_sel, win_ok;
  assign win_sel = addr_i[AW-1];
  assign wr_mode = req_i &  we_i & !win_sel & (addr_i == AW'(OFF_MODE));
  assign wr_cmd  = req_i &  we_i & !win_sel & (addr_i == AW'(OFF_CMD));
  assign wr_buf  = req_i &  we_i & !win_sel & (addr_i == AW'(OFF_BUF));
  assign rd_stat = req_i & !we_i & !win_sel & (addr_i == AW'(OFF_STAT));

  logic [FMCN_W-1:0] fmcn_q;
  logic              fws_q;
  logic [31:0]       pbuf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmcn_q <= '0;
      fws_q  <= 1'b0;
      pbuf_q <= '0;
    end else begin
      if (wr_mode) begin
        fmcn_q <= wdata_i[16 +: FMCN_W];
        fws_q  <= wdata_i[8];
      end
      if (wr_buf) pbuf_q <= wdata_i;
    end
  end

  logic                   busy, done;
  logic                   cmd_accept, prog_err, lock_err;
  flc_op_e                dec_op;
  logic [PG_W-1:0]        dec_pn;
  logic [NUM_REGIONS-1:0] lock_q;
  logic [NUM_GP-1:0]      gp_q;

  flc_cmd_decode #(
    .NUM_REGIONS(NUM_REGIONS), .PAGES_PER_REGION(PAGES_PER_REGION), .NUM_GP(NUM_GP)
  ) u_dec (
    .cmd_wr_i(wr_cmd), .word_i(wdata_i), .busy_i(busy), .lock_i(lock_q),
    .accept_o(cmd_accept), .prog_err_o(prog_err), .lock_err_o(lock_err),
    .op_o(dec_op), .pn_o(dec_pn)
  );

  logic [CNT_W-1:0] base_len, busy_len;
  assign base_len = CNT_W'(fmcn_q) + CNT_W'(1);
  assign busy_len = fws_q ? {base_len[CNT_W-2:0], 1'b0} : base_len;

  flc_busy_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i, .rst_ni, .load_i(cmd_accept), .len_i(busy_len),
    .busy_o(busy), .done_o(done)
  );

  flc_op_e         op_q;
  logic [PG_W-1:0] pn_q;
  logic [31:0]     data_q;
  logic            perr_q, lerr_q, eol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_WRITE;
      pn_q   <= '0;
      data_q <= '0;
      perr_q <= 1'b0;
      lerr_q <= 1'b0;
      eol_q  <= 1'b0;
    end else begin
      if (cmd_accept) begin
        op_q   <= dec_op;
        pn_q   <= dec_pn;
        data_q <= pbuf_q;
      end
      // a new error on the read edge wins over the clear
      if (prog_err)     perr_q <= 1'b1;
      else if (rd_stat) perr_q <= 1'b0;
      if (lock_err)     lerr_q <= 1'b1;
      else if (rd_stat) lerr_q <= 1'b0;
      if (cmd_accept && is_lock_op(dec_op)) eol_q <= 1'b0;
      else if (done && is_lock_op(op_q))    eol_q <= 1'b1;
    end
  end

  logic [WIN_W-1:0] win_idx;
  logic [31:0]      page_data;
  assign win_idx = addr_i[AW-2:2];
  assign win_ok  = 32'(win_idx) < NUM_PAGES;

  flc_nvm_store #(
    .NUM_REGIONS(NUM_REGIONS), .PAGES_PER_REGION(PAGES_PER_REGION), .NUM_GP(NUM_GP)
  ) u_store (
    .clk_i, .rst_ni, .done_i(done), .op_i(op_q), .pn_i(pn_q), .data_i(data_q),
    .rd_idx_i(win_idx[PG_W-1:0]), .rd_data_o(page_data),
    .lock_o(lock_q), .gp_o(gp_q)
  );

  logic [31:0] status;
  always_comb begin
    status                        = '0;
    status[ST_RDY]                = ~busy;
    status[ST_EOL]                = eol_q;
    status[ST_LERR]               = lerr_q;
    status[ST_PERR]               = perr_q;
    status[ST_SEC]                = sec_i;
    status[ST_GP +: NUM_GP]       = gp_q;
    status[ST_LOCK +: NUM_REGIONS] = lock_q;
  end

  always_comb begin
    rdata_o = '0;
    if (win_sel) begin
      rdata_o = win_ok ? page_data : '0;
    end else begin
      case (addr_i)
        AW'(OFF_MODE): rdata_o = {8'h00, fmcn_q, 7'h00, fws_q, 8'h00};
        AW'(OFF_STAT): rdata_o = status;
        AW'(OFF_BUF):  rdata_o = pbuf_q;
        default:       rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/flc_ctrl_chk.sv
module flc_ctrl_chk #(
  parameter int NUM_REGIONS = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   accept_i,
  input logic                   prog_err_i,
  input logic                   lock_err_i,
  input logic                   busy_i,
  input logic                   done_i,
  input logic                   perr_i,
  input logic                   lerr_i,
  input logic                   eol_i,
  input logic                   rd_stat_i,
  input logic [NUM_REGIONS-1:0] lock_i
);
  // R4
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> busy_i);

  // R5
  busy_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !accept_i);

  // R2
  perr_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_err_i |=> perr_i);

  // R7
  lerr_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_err_i |=> lerr_i);

  // R12
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat_i && !prog_err_i) |=> !perr_i);

  // R9
  eol_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eol_i) |-> $past(done_i));

  // R8
  lock_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lock_i) |-> $past(done_i));
endmodule

bind flc_ctrl flc_ctrl_chk #(.NUM_REGIONS(NUM_REGIONS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .accept_i(cmd_accept), .prog_err_i(prog_err),
  .lock_err_i(lock_err), .busy_i(busy), .done_i(done), .perr_i(perr_q),
  .lerr_i(lerr_q), .eol_i(eol_q), .rd_stat_i(rd_stat), .lock_i(lock_q)
);

// File: tb/test_flc_ctrl.sv
`timescale 1ns/1ps
module test_flc_ctrl;
  localparam int NRG = 8, PPR = 4, NGP = 3, NPG = NRG * PPR;
  localparam logic [7:0] A_MODE = 8'h00, A_CMD = 8'h04, A_STAT = 8'h08, A_BUF = 8'h0C;

  logic clk = 1'b0, rst_ni = 1'b0, req_i = 1'b0, we_i = 1'b0, sec_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;

  flc_ctrl i_flc_ctrl (
    .clk_i(clk), .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .sec_i, .rdata_o
  );

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] m_mem [NPG];
  logic [NRG-1:0] m_lock = '0;
  logic [NGP-1:0] m_gp = '0;
  logic m_eol = 1'b0, m_perr = 1'b0, m_lerr = 1'b0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_stat(input logic rdy);
    logic [31:0] s = '0;
    s[0] = rdy; s[1] = m_eol; s[2] = m_lerr; s[3] = m_perr; s[4] = sec_i;
    s[8 +: NGP] = m_gp; s[16 +: NRG] = m_lock;
    return s;
  endfunction

  function automatic logic [31:0] cmd(input int pn, input logic [7:0] op);
    return {8'h5A, 6'h00, 10'(pn), op};
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk); #1; req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1; d = rdata_o;
    @(posedge clk); #1; req_i = 1'b0;
  endtask

  task automatic stat_chk(input string tag, input logic rdy);
    logic [31:0] d;
    rd(A_STAT, d);
    chk(tag, d, exp_stat(rdy));
    m_perr = 1'b0; m_lerr = 1'b0;
  endtask

  task automatic wait_idle(output int lows);
    logic [31:0] d;
    lows = 0;
    for (int i = 0; i < 2000; i++) begin
      rd(A_STAT, d);
      if (d[0]) break;
      lows++;
    end
  endtask

  task automatic page_chk(input string tag, input int p);
    logic [31:0] d;
    rd(8'h80 + 8'(4 * p), d);
    chk(tag, d, m_mem[p]);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int lows;
    for (int p = 0; p < NPG; p++) m_mem[p] = 32'hFFFFFFFF;
    #12; rst_ni = 1'b1;

    // R1 reset state
    stat_chk("R1 status", 1'b1);
    rd(A_MODE, d); chk("R1 mode", d, 32'h0);
    page_chk("R1 page0", 0);
    page_chk("R1 last page", NPG - 1);

    // R4 busy length sweep, R6 data stored
    for (int f = 0; f < 4; f++) begin
      for (int w = 0; w < 2; w++) begin
        int fm = f * 3;
        int p = f * 2 + w;
        wr(A_MODE, {8'h00, 8'(fm), 7'h00, 1'(w), 8'h00});
        wr(A_BUF, 32'hC0DE0000 + 32'(p));
        wr(A_CMD, cmd(p, 8'h01));
        wait_idle(lows);
        chk("R4 busy cycles", 32'(lows), 32'((fm + 1) << w));
        m_mem[p] = 32'hC0DE0000 + 32'(p);
        page_chk("R6 page after timed write", p);
      end
    end

    // R6 every page with a distinct pattern
    wr(A_MODE, 32'h0);
    for (int p = 0; p < NPG; p++) begin
      wr(A_BUF, {8'(p), 8'(~p), 8'(p * 7), 8'hA5});
      wr(A_CMD, cmd(p, 8'h01));
      wait_idle(lows);
      m_mem[p] = {8'(p), 8'(~p), 8'(p * 7), 8'hA5};
    end
    for (int p = 0; p < NPG; p++) page_chk("R6 sweep", p);
    stat_chk("R9 eol untouched by write", 1'b1);

    // R2 wrong key, R12 clear on read
    wr(A_BUF, 32'h12345678);
    wr(A_CMD, {8'h5B, 6'h0, 10'd3, 8'h01});
    m_perr = 1'b1;
    stat_chk("R2 bad key", 1'b1);
    stat_chk("R12 cleared after read", 1'b1);
    page_chk("R2 page untouched", 3);

    // R3 unknown opcode and ranges
    wr(A_CMD, cmd(2, 8'h03));  m_perr = 1'b1; stat_chk("R3 unknown opcode", 1'b1);
    wr(A_CMD, cmd(NPG, 8'h01)); m_perr = 1'b1; stat_chk("R3 page range", 1'b1);
    wr(A_CMD, cmd(NPG + 5, 8'h02)); m_perr = 1'b1; stat_chk("R3 lock range", 1'b1);
    wr(A_CMD, cmd(NGP, 8'h0B)); m_perr = 1'b1; stat_chk("R3 gp range", 1'b1);
    page_chk("R3 page untouched", 2);

    // R5 command while busy
    wr(A_MODE, {8'h00, 8'd20, 16'h0});
    wr(A_BUF, 32'hBEEF0001);
    wr(A_CMD, cmd(1, 8'h01));
    wr(A_CMD, cmd(0, 8'h0B));
    m_perr = 1'b1;
    stat_chk("R5 rejected while busy", 1'b0);
    wait_idle(lows);
    m_mem[1] = 32'hBEEF0001;
    stat_chk("R5 gp unchanged, R12 cleared", 1'b1);
    page_chk("R5 running write completed", 1);

    // R8 lock each region from a different page inside it, R9 eol
    wr(A_MODE, {8'h00, 8'd2, 16'h0});
    for (int r = 0; r < NRG; r++) begin
      wr(A_CMD, cmd(r * PPR + (r % PPR), 8'h02));
      m_eol = 1'b0;
      stat_chk("R9 eol low while locking", 1'b0);
      wait_idle(lows);
      m_lock[r] = 1'b1; m_eol = 1'b1;
      stat_chk("R8 lock region", 1'b1);
    end

    // R7 write to locked region, R10 erase refused
    for (int r = 0; r < NRG; r++) begin
      wr(A_BUF, 32'h0);
      wr(A_CMD, cmd(r * PPR + PPR - 1, 8'h01));
      m_lerr = 1'b1;
      stat_chk("R7 locked write", 1'b1);
      page_chk("R7 page kept", r * PPR + PPR - 1);
    end
    wr(A_CMD, cmd(0, 8'h08));
    m_lerr = 1'b1;
    stat_chk("R10 erase refused", 1'b1);
    page_chk("R10 page kept", 5);

    // R8 unlock even regions via another page of the region
    for (int r = 0; r < NRG; r += 2) begin
      wr(A_CMD, cmd(r * PPR + 1, 8'h04));
      wait_idle(lows);
      m_lock[r] = 1'b0;
    end
    stat_chk("R8 even unlocked", 1'b1);
    wr(A_BUF, 32'h0F0F0F0F);
    wr(A_CMD, cmd(2 * PPR, 8'h01));
    wait_idle(lows);
    m_mem[2 * PPR] = 32'h0F0F0F0F;
    page_chk("R7 unlocked region writable", 2 * PPR);
    for (int r = 1; r < NRG; r += 2) begin
      wr(A_CMD, cmd(r * PPR + 2, 8'h04));
      wait_idle(lows);
      m_lock[r] = 1'b0;
    end
    stat_chk("R8 all unlocked", 1'b1);

    // R10 erase all
    wr(A_CMD, cmd(0, 8'h08));
    wait_idle(lows);
    for (int p = 0; p < NPG; p++) m_mem[p] = 32'hFFFFFFFF;
    for (int p = 0; p < NPG; p++) page_chk("R10 erased", p);

    // R11 general-purpose bits
    for (int b = 0; b < NGP; b++) begin
      wr(A_CMD, cmd(b, 8'h0B));
      wait_idle(lows);
      m_gp[b] = 1'b1;
      stat_chk("R11 gp set", 1'b1);
    end
    wr(A_CMD, cmd(1, 8'h0D));
    wait_idle(lows);
    m_gp[1] = 1'b0;
    stat_chk("R11 gp clear", 1'b1);

    // R13 security input
    sec_i = 1'b1;
    stat_chk("R13 security set", 1'b1);
    sec_i = 1'b0;
    stat_chk("R13 security clear", 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule